// File: doc/BRIEF.md
# Digital Potentiometer Command Engine

This block executes the register commands of a digitally controlled potentiometer. A serial bus front end handles address matching and bit timing. It passes the engine framing strobes (start, which also covers a repeated start, and stop) and the received bytes one at a time. The engine decodes the instruction byte. It then reads or writes the 6-bit wiper register, reads or writes one of four 6-bit data registers, copies between the wiper and a data register, or enters a stepping mode in which single pulses move the wiper up or down.

The data registers stand in for nonvolatile cells. A store into one of them waits until the stop condition closes the frame. It then runs for a parameterised number of clock cycles, and a busy flag stays raised for that time. A low level on the write-protect input suppresses stores. At reset the data registers take their parameter values and the wiper takes the value of data register 0.

Top module: `pot_cmd_engine`

## Requirements
- R1: After reset the wiper output equals data register 0's initial value, busy is low, and the acknowledge and transmit-valid outputs are low.
- R2: The instruction byte holds the opcode in bits 7:4, the register select in bits 3:2, and zeros in bits 1:0. An accepted byte raises `ack_o` for exactly one cycle, in the cycle after `byte_vld_i`.
- R3: Opcode 1001 (read wiper) raises `tx_vld_o` together with `ack_o`, with `tx_byte_o` = {2'b00, wiper}.
- R4: Opcode 1011 (read data register) returns {2'b00, selected register} in the same way.
- R5: Opcode 1010 (write wiper) takes the next byte. If its bits 7:6 are zero, that byte is acknowledged and the wiper takes bits 5:0 one cycle later. Otherwise the byte is not acknowledged and the wiper is unchanged.
- R6: Opcode 1101 copies the selected data register into the wiper one cycle after the instruction byte, with no busy period.
- R7: Opcode 1100 (with a data byte of the R5 format) and opcode 1110 (copy wiper to register) defer their store to the stop condition. Busy then rises in the cycle after stop and stays high for exactly STORE_CYC cycles. The register holds the new value once busy falls.
- R8: If `wp_n_i` is low at the stop condition, no store happens and busy stays low.
- R9: A start condition that arrives before the stop condition discards a pending store.
- R10: An unknown opcode, or nonzero bits 1:0, is not acknowledged and changes nothing. The bytes that follow are ignored until the next start.
- R11: While busy is high, an instruction byte is not acknowledged and has no effect.
- R12: Opcode 0010 enters stepping mode. Each `step_i` pulse moves the wiper +1 when `step_up_i` is 1, or −1 when it is 0, saturating at 63 and 0. Steps outside this mode, or in a cycle with a start or stop, are ignored. The mode ends at start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start strobe after address match |
| stop_i | input | 1 | Stop condition strobe |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| step_i | input | 1 | Stepping pulse |
| step_up_i | input | 1 | Step direction, 1 = up |
| wp_n_i | input | 1 | Write protect, low blocks stores |
| ack_o | output | 1 | Acknowledge for the previous byte |
| tx_vld_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Byte to send to the host |
| wiper_o | output | 6 | Wiper register |
| busy_o | output | 1 | Store cycle in progress |

## Verification
Two events can share one cycle: a step pulse and the start strobe that ends stepping mode. The bench drives `step_i` and `start_i` on the same edge while in stepping mode. It requires the wiper to stay put and later step pulses to be ignored, because start takes priority. A second collision is a stop strobe that closes a store frame while write protect is low. The bench judges that case by busy staying low and by a read-back of the untouched register.

// File: rtl/pot_cmd_engine.sv
module pot_cmd_engine #(
  parameter int          STORE_CYC = 40,
  parameter logic [23:0] DR_INIT   = 24'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       step_i,
  input  logic       step_up_i,
  input  logic       wp_n_i,
  output logic       ack_o,
  output logic       tx_vld_o,
  output logic [7:0] tx_byte_o,
  output logic [5:0] wiper_o,
  output logic       busy_o
);
  localparam int CW = $clog2(STORE_CYC + 1);

  typedef enum logic [1:0] {P_IDLE, P_INSTR, P_DATA, P_STEP} phase_t;

  phase_t          phase;
  logic [3:0][5:0] dr;
  logic [5:0]      wiper;
  logic            busy;
  logic [CW-1:0]   cnt;
  logic            to_dr;
  logic [1:0]      sel_q;
  logic            pend;
  logic [1:0]      pend_sel, st_sel;
  logic [5:0]      pend_val, st_val;
  logic            known;

  wire [3:0] opc  = byte_i[7:4];
  wire [1:0] rsel = byte_i[3:2];

  always_comb begin
    case (opc)
      4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'h2: known = 1'b1;
      default:                                 known = 1'b0;
    endcase
  end

  wire instr_ok = known && (byte_i[1:0] == 2'b00) && !busy;

  assign wiper_o = wiper;
  assign busy_o  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr        <= DR_INIT;
      wiper     <= DR_INIT[5:0];
      busy      <= 1'b0;
      cnt       <= '0;
      phase     <= P_IDLE;
      to_dr     <= 1'b0;
      sel_q     <= '0;
      pend      <= 1'b0;
      pend_sel  <= '0;
      pend_val  <= '0;
      st_sel    <= '0;
      st_val    <= '0;
      ack_o     <= 1'b0;
      tx_vld_o  <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      ack_o    <= 1'b0;
      tx_vld_o <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          dr[st_sel] <= st_val;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (start_i) begin
        phase <= P_INSTR;
        pend  <= 1'b0;
      end else if (stop_i) begin
        phase <= P_IDLE;
        pend  <= 1'b0;
        if (pend && wp_n_i && !busy) begin
          busy   <= 1'b1;
          cnt    <= CW'(STORE_CYC - 1);
          st_sel <= pend_sel;
          st_val <= pend_val;
        end
      end else if (byte_vld_i) begin
        case (phase)
          P_INSTR: begin
            phase <= P_IDLE;
            if (instr_ok) begin
              ack_o <= 1'b1;
              case (opc)
                4'h9: begin tx_vld_o <= 1'b1; tx_byte_o <= {2'b00, wiper}; end
                4'hB: begin tx_vld_o <= 1'b1; tx_byte_o <= {2'b00, dr[rsel]}; end
                4'hA: begin phase <= P_DATA; to_dr <= 1'b0; end
                4'hC: begin phase <= P_DATA; to_dr <= 1'b1; sel_q <= rsel; end
                4'hD: wiper <= dr[rsel];
                4'hE: begin pend <= 1'b1; pend_sel <= rsel; pend_val <= wiper; end
                default: phase <= P_STEP;
              endcase
            end
          end
          P_DATA: begin
            phase <= P_IDLE;
            if (byte_i[7:6] == 2'b00) begin
              ack_o <= 1'b1;
              if (to_dr) begin
                pend     <= 1'b1;
                pend_sel <= sel_q;
                pend_val <= byte_i[5:0];
              end else begin
                wiper <= byte_i[5:0];
              end
            end
          end
          default: ;
        endcase
      end else if (step_i && phase == P_STEP) begin
        if (step_up_i && wiper != 6'h3F) wiper <= wiper + 1'b1;
        else if (!step_up_i && wiper != 6'h00) wiper <= wiper - 1'b1;
      end
    end
  end

  p_busy_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  p_dr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dr));

  p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !wp_n_i && !busy) |=> !busy_o);

  p_busy_noack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i && phase == P_INSTR && busy) |=> !ack_o);

  p_bad_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i && phase == P_INSTR && !known) |=> !ack_o);

  p_tx_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld_o |-> ack_o);

  p_step_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_STEP && step_i && step_up_i && !start_i && !stop_i && !byte_vld_i
     && wiper == 6'h3F) |=> wiper_o == 6'h3F);

  p_step_bottom_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_STEP && step_i && !step_up_i && !start_i && !stop_i && !byte_vld_i
     && wiper == 6'h00) |=> wiper_o == 6'h00);
endmodule

// File: tb/pot_cmd_engine_tb.sv
module pot_cmd_engine_tb;
  localparam int SC = 20;
  localparam logic [23:0] INIT = {6'h0C, 6'h33, 6'h22, 6'h11};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, step_i = 0, step_up_i = 0, wp_n_i = 1;
  logic [7:0] byte_i = 0;
  logic ack_o, tx_vld_o, busy_o;
  logic [7:0] tx_byte_o;
  logic [5:0] wiper_o;

  int checks = 0, errors = 0;
  logic g_ack, g_tv;
  logic [7:0] g_tx;

  always #5 clk = ~clk;

  pot_cmd_engine #(.STORE_CYC(SC), .DR_INIT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .step_i(step_i), .step_up_i(step_up_i),
    .wp_n_i(wp_n_i), .ack_o(ack_o), .tx_vld_o(tx_vld_o), .tx_byte_o(tx_byte_o),
    .wiper_o(wiper_o), .busy_o(busy_o));

  // {data byte, expected ack, 1'b0, expected wiper after}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 1'b1, 1'b0, 6'h00}, {8'h3F, 1'b1, 1'b0, 6'h3F},
    {8'h15, 1'b1, 1'b0, 6'h15}, {8'h2A, 1'b1, 1'b0, 6'h2A},
    {8'h40, 1'b0, 1'b0, 6'h2A}, {8'hA5, 1'b0, 1'b0, 6'h2A}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1; byte_i = b;
    @(negedge clk); byte_vld_i = 0;
    g_ack = ack_o; g_tv = tx_vld_o; g_tx = tx_byte_o;
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask

  task automatic step(input logic up);
    @(negedge clk); step_i = 1; step_up_i = up;
    @(negedge clk); step_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * SC && busy_o; i++) @(negedge clk);
  endtask

  task automatic wr_wiper(input logic [7:0] d);
    do_start(); send(8'hA0); send(d); do_stop();
  endtask

  task automatic rd_dr(input logic [1:0] s, input string req, input logic [5:0] exp);
    do_start(); send(8'hB0 | {4'h0, s, 2'b00}); do_stop();
    check(req, {g_ack, g_tv}, 8'h03);
    check(req, g_tx, {2'b00, exp});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wiper", {2'b0, wiper_o}, 8'h11);
    check("R1 flags", {busy_o, ack_o, tx_vld_o}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R5 and R3 through the vector table
    foreach (VEC[i]) begin
      do_start(); send(8'hA0);
      check("R2 instr ack", g_ack, 8'h01);
      send(VEC[i][15:8]); do_stop();
      check("R5 data ack", g_ack, VEC[i][7]);
      check("R5 wiper", wiper_o, VEC[i][5:0]);
      do_start(); send(8'h90); do_stop();
      check("R3 read wiper", {g_ack, g_tv}, 8'h03);
      check("R3 tx byte", g_tx, {2'b00, VEC[i][5:0]});
    end

    // R4 read data registers
    rd_dr(2'd1, "R4 dr1", 6'h22);
    rd_dr(2'd3, "R4 dr3", 6'h0C);

    // R6 copy dr2 to wiper, no busy
    do_start(); send(8'hD8);
    check("R6 wiper", wiper_o, 8'h33);
    check("R6 busy", busy_o, 8'h00);
    do_stop();
    check("R6 no busy after stop", busy_o, 8'h00);

    // R10 bad opcode and bad low bits
    do_start(); send(8'hF0);
    check("R10 ack F0", g_ack, 8'h00);
    send(8'h3F);
    check("R10 trailing byte", {g_ack, 2'b0, wiper_o}, 8'h33);
    do_stop();
    do_start(); send(8'h91);
    check("R10 low bits", {g_ack, g_tv}, 8'h00);
    do_stop();

    // R8 write protect blocks store
    wp_n_i = 0;
    do_start(); send(8'hC4); send(8'h3A);
    check("R8 data ack", g_ack, 8'h01);
    do_stop();
    check("R8 busy", busy_o, 8'h00);
    wp_n_i = 1;
    rd_dr(2'd1, "R8 dr1 kept", 6'h22);

    // R9 repeated start aborts store
    do_start(); send(8'hC8); send(8'h01);
    do_start(); do_stop();
    check("R9 busy", busy_o, 8'h00);
    rd_dr(2'd2, "R9 dr2 kept", 6'h33);

    // R7 store timing
    do_start(); send(8'hC8); send(8'h2D);
    check("R7 data no busy", busy_o, 8'h00);
    do_stop();
    check("R7 busy rise", busy_o, 8'h01);
    repeat (SC - 1) @(negedge clk);
    check("R7 busy last", busy_o, 8'h01);
    @(negedge clk);
    check("R7 busy fall", busy_o, 8'h00);
    rd_dr(2'd2, "R7 dr2 new", 6'h2D);

    // R7 copy wiper to dr0, R11 blocked while busy
    wr_wiper(8'h27);
    do_start(); send(8'hE0); do_stop();
    check("R7 copy busy", busy_o, 8'h01);
    do_start(); send(8'h90);
    check("R11 no ack", {g_ack, g_tv}, 8'h00);
    do_stop();
    do_start(); send(8'hD4);
    check("R11 copy blocked", wiper_o, 8'h27);
    do_stop();
    wait_idle();
    rd_dr(2'd0, "R7 dr0 copy", 6'h27);

    // R12 stepping and saturation
    wr_wiper(8'h3E);
    do_start(); send(8'h20);
    check("R12 ack", g_ack, 8'h01);
    step(1); check("R12 up", wiper_o, 8'h3F);
    step(1); check("R12 top", wiper_o, 8'h3F);
    step(0); check("R12 down", wiper_o, 8'h3E);
    do_stop();
    step(0); check("R12 outside mode", wiper_o, 8'h3E);
    wr_wiper(8'h01);
    do_start(); send(8'h20);
    step(0); check("R12 down 0", wiper_o, 8'h00);
    step(0); check("R12 bottom", wiper_o, 8'h00);
    step(1); check("R12 up 1", wiper_o, 8'h01);
    @(negedge clk); start_i = 1; step_i = 1; step_up_i = 1;
    @(negedge clk); start_i = 0; step_i = 0;
    check("R12 start wins", wiper_o, 8'h01);
    step(1); check("R12 mode ended", wiper_o, 8'h01);
    do_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule